// File: doc/BRIEF.md
# Byte-Access ECC Wrapper with Read-Modify-Write

This block sits between a byte-wide request port and an external word store. The store holds 32-bit units with 6 Hamming check bits each, 38 bits per entry. A unit is the four bytes whose byte addresses agree in every bit above bit 1. On a read, the wrapper fetches the entry and repairs any single flipped bit. It then returns the byte picked by address bits 1..0 and pulses a flag when a repair took place.

On a write, the wrapper fetches the whole entry and repairs it, then replaces one byte lane and computes fresh check bits. It stores the complete 38-bit entry back, so writing a single byte always rewrites all four bytes and all six check bits. After reset, the wrapper fills every entry with the codeword for all-ones data. Every byte therefore reads FFh with clean check bits. The store is external and has a one-cycle read latency.

Top module: `ecc_byte_rmw`

## Requirements
- R1: After reset, busy stays high while every word address from 0 upwards is written with the codeword of all-ones data. Afterwards any byte reads FFh with the flag low.
- R2: A read returns the byte of the unit picked by address bits 1..0, where lane 0 is data bits 7..0 and lane 3 is bits 31..24. rd_valid is high for exactly the second cycle after the accepting edge.
- R3: Stored word bit p-1 holds Hamming position p (1..38). Parity sits at positions 1, 2, 4, 8, 16 and 32, and data bit i sits at the i-th remaining position, so data bit 0 is at position 3. A single flipped data position is corrected in the returned byte, and corrected is raised with rd_valid.
- R4: A single flipped check position leaves the returned data unchanged and still raises corrected.
- R5: When the syndrome is zero, corrected stays low.
- R6: A byte write reads the unit, corrects it, and replaces only the addressed lane. It then writes back the full 38-bit entry at the same word address, with a zero syndrome.
- R7: A request is accepted only while busy is low. After a write is accepted, busy stays high for two cycles and then falls. A request presented while busy is high has no effect.
- R8: A write to a unit that holds a single-bit error stores the corrected contents of the other three lanes, so later reads of that unit return clean data with the flag low.
- R9: rd_valid and corrected are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | ADDR_W | Byte address |
| req_wbyte | input | 8 | Byte to write |
| busy | output | 1 | Fill or operation in progress |
| rd_valid | output | 1 | Read byte valid pulse |
| rd_byte | output | 8 | Returned byte |
| corrected | output | 1 | Single-bit repair seen on this read |
| mem_en | output | 1 | Store access enable |
| mem_we | output | 1 | Store write enable |
| mem_addr | output | ADDR_W-2 | Store word address |
| mem_wword | output | 38 | Codeword to store |
| mem_rword | input | 38 | Codeword read from the store (one cycle after a read) |

## Verification
On every cycle, the assertions check that each entry written to the store has a zero syndrome. They also check that store writes happen only while busy, that a write-back targets the word fetched two cycles earlier, that an accepted request raises busy, and that the read and flag outputs are single-cycle pulses. Only the bench scenarios can show the actual byte values: lane selection, merge results, repair of injected data-bit and check-bit faults, the all-ones fill, and that a request made while busy leaves memory untouched.

// File: rtl/ecc_byte_rmw.sv
`timescale 1ns/1ps
module ecc_byte_rmw #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wbyte,
  output logic              busy,
  output logic              rd_valid,
  output logic [7:0]        rd_byte,
  output logic              corrected,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_addr,
  output logic [37:0]       mem_wword,
  input  logic [37:0]       mem_rword
);
  localparam int DW = 32;
  localparam int PW = 6;
  localparam int CW = DW + PW;
  localparam int WAW = ADDR_W - 2;
  localparam int LANES = DW / 8;
  localparam int LW = $clog2(LANES);

  function automatic logic [CW-1:0] encode(input logic [DW-1:0] d);
    logic [CW:1] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p <= CW; p++)
      if ((p & (p - 1)) != 0) begin
        c[p] = d[k];
        k++;
      end
    for (int b = 0; b < PW; b++)
      for (int p = 1; p <= CW; p++)
        if (p[b] && ((p & (p - 1)) != 0)) c[1 << b] = c[1 << b] ^ c[p];
    return c;
  endfunction

  function automatic logic [PW-1:0] syndrome(input logic [CW-1:0] w);
    logic [PW-1:0] s;
    s = '0;
    for (int p = 1; p <= CW; p++)
      if (w[p-1]) s = s ^ PW'(p);
    return s;
  endfunction

  function automatic logic [DW-1:0] extract(input logic [CW-1:0] w);
    logic [DW-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p <= CW; p++)
      if ((p & (p - 1)) != 0) begin
        d[k] = w[p-1];
        k++;
      end
    return d;
  endfunction

  localparam logic [CW-1:0] FILL_CW = encode('1);

  typedef enum logic [1:0] {S_FILL, S_IDLE, S_FETCH, S_STORE} state_t;

  state_t          state;
  logic [WAW-1:0]  fill_cnt, wa;
  logic [LW-1:0]   lane;
  logic            wr;
  logic [7:0]      wbyte;
  logic [DW-1:0]   merged;
  logic [PW-1:0]   syn;
  logic [CW-1:0]   fixed_w;
  logic [DW-1:0]   fixed_d;

  assign syn = syndrome(mem_rword);

  always_comb begin
    fixed_w = mem_rword;
    for (int p = 1; p <= CW; p++)
      if (syn == PW'(p)) fixed_w[p-1] = ~mem_rword[p-1];
  end

  assign fixed_d   = extract(fixed_w);
  assign busy      = state != S_IDLE;
  assign mem_we    = (state == S_FILL) || (state == S_STORE);
  assign mem_en    = mem_we || (state == S_IDLE && req_valid);
  assign mem_addr  = (state == S_FILL) ? fill_cnt : (state == S_IDLE) ? req_addr[ADDR_W-1:2] : wa;
  assign mem_wword = (state == S_FILL) ? FILL_CW : encode(merged);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_FILL;
      fill_cnt  <= '0;
      wa        <= '0;
      lane      <= '0;
      wr        <= 1'b0;
      wbyte     <= '0;
      merged    <= '0;
      rd_byte   <= '0;
      rd_valid  <= 1'b0;
      corrected <= 1'b0;
    end else begin
      rd_valid  <= 1'b0;
      corrected <= 1'b0;
      case (state)
        S_FILL: begin
          fill_cnt <= fill_cnt + 1'b1;
          if (fill_cnt == {WAW{1'b1}}) state <= S_IDLE;
        end
        S_IDLE: if (req_valid) begin
          wa    <= req_addr[ADDR_W-1:2];
          lane  <= req_addr[LW-1:0];
          wr    <= req_write;
          wbyte <= req_wbyte;
          state <= S_FETCH;
        end
        S_FETCH: begin
          if (wr) begin
            for (int l = 0; l < LANES; l++)
              merged[l*8 +: 8] <= (lane == LW'(l)) ? wbyte : fixed_d[l*8 +: 8];
            state <= S_STORE;
          end else begin
            rd_byte   <= fixed_d[lane*8 +: 8];
            rd_valid  <= 1'b1;
            corrected <= syn != '0;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecc_byte_rmw_chk.sv
`timescale 1ns/1ps
module ecc_byte_rmw_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              rd_valid,
  input logic              corrected,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-3:0] mem_addr,
  input logic [37:0]       mem_wword
);
  function automatic logic clean(input logic [37:0] w);
    logic [5:0] acc;
    acc = '0;
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < 38; i++)
        if (((i + 1) >> b) & 1) acc[b] = acc[b] ^ w[i];
    return acc == '0;
  endfunction

  a_r6_clean_codeword: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> clean(mem_wword));
  a_r6_same_unit: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && $past(mem_en && !mem_we, 2)) |-> mem_addr == $past(mem_addr, 2));
  a_r7_write_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  a_r7_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);
  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  a_r5_flag_with_data: assert property (@(posedge clk) disable iff (!rst_n)
    corrected |-> rd_valid);
endmodule

bind ecc_byte_rmw ecc_byte_rmw_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .rd_valid(rd_valid), .corrected(corrected), .mem_en(mem_en),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wword(mem_wword)
);

// File: tb/tb_ecc_byte_rmw.sv
`timescale 1ns/1ps
module tb_ecc_byte_rmw;
  localparam int AW = 8;
  localparam int WORDS = 1 << (AW - 2);
  localparam int NV = 14;
  // {write, addr, data, expected}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h10, 8'hAA, 8'h00}, {1'b1, 8'h11, 8'hBB, 8'h00},
    {1'b1, 8'h13, 8'hCC, 8'h00}, {1'b0, 8'h10, 8'h00, 8'hAA},
    {1'b0, 8'h11, 8'h00, 8'hBB}, {1'b0, 8'h12, 8'h00, 8'hFF},
    {1'b0, 8'h13, 8'h00, 8'hCC}, {1'b1, 8'h10, 8'h11, 8'h00},
    {1'b0, 8'h10, 8'h00, 8'h11}, {1'b0, 8'h11, 8'h00, 8'hBB},
    {1'b1, 8'hFF, 8'h5A, 8'h00}, {1'b0, 8'hFC, 8'h00, 8'hFF},
    {1'b0, 8'hFF, 8'h00, 8'h5A}, {1'b0, 8'h00, 8'h00, 8'hFF}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_wbyte = '0;
  logic busy, rd_valid, corrected, mem_en, mem_we;
  logic [7:0] rd_byte;
  logic [AW-3:0] mem_addr;
  logic [37:0] mem_wword, mem_rword;
  logic [37:0] arr [WORDS];
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ecc_byte_rmw #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wbyte(req_wbyte), .busy(busy), .rd_valid(rd_valid),
    .rd_byte(rd_byte), .corrected(corrected), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wword(mem_wword), .mem_rword(mem_rword)
  );

  always @(posedge clk)
    if (mem_en) begin
      if (mem_we) arr[mem_addr] <= mem_wword;
      else mem_rword <= arr[mem_addr];
    end

  function automatic logic [5:0] tb_syn(input logic [37:0] w);
    logic [5:0] s = '0;
    for (int i = 0; i < 38; i++) if (w[i]) s ^= 6'(i + 1);
    return s;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_req(input logic we, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = we; req_addr = a; req_wbyte = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] b, output logic f);
    int t = 0;
    do_req(0, a, 8'h00);
    while (!rd_valid && t < 10) begin @(negedge clk); t++; end
    b = rd_byte; f = corrected;
    @(negedge clk);
    check(!rd_valid && !corrected, "R9 pulse", rd_valid, 0);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    int t = 0;
    do_req(1, a, d);
    while (busy && t < 10) begin @(negedge clk); t++; end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic f;
    int cyc;
    repeat (3) @(negedge clk);
    check(busy && !rd_valid, "R1 reset state", {busy, rd_valid}, 2);
    rst_n = 1;
    cyc = 0;
    while (busy && cyc < 1000) begin @(negedge clk); cyc++; end
    check(cyc >= WORDS && cyc <= WORDS + 2, "R1 fill length", cyc, WORDS);
    do_read(8'h37, b, f);
    check(b == 8'hFF && !f, "R1 filled byte", {f, b}, 8'hFF);
    check(tb_syn(arr[WORDS-1]) == 0, "R1 fill codeword", tb_syn(arr[WORDS-1]), 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) begin
        do_write(VEC[i][23:16], VEC[i][15:8]);
        check(tb_syn(arr[VEC[i][23:18]]) == 0, "R6 stored syndrome", tb_syn(arr[VEC[i][23:18]]), 0);
      end else begin
        do_read(VEC[i][23:16], b, f);
        check(b == VEC[i][7:0] && !f, "R2 lane read", {f, b}, VEC[i][7:0]);
      end
    end

    // R3: flip data bit 0 (position 3, stored bit 2) of unit 0x10
    @(negedge clk); arr[4][2] = ~arr[4][2];
    do_read(8'h10, b, f);
    check(b == 8'h11 && f, "R3 data repair", {f, b}, 9'h111);
    do_read(8'h13, b, f);
    check(b == 8'hCC && f, "R3 repaired other lane", {f, b}, 9'h1CC);

    // R4: flip check bits at positions 1 and 32
    @(negedge clk); arr[8][0] = ~arr[8][0]; arr[12][31] = ~arr[12][31];
    do_read(8'h21, b, f);
    check(b == 8'hFF && f, "R4 check bit p1", {f, b}, 9'h1FF);
    do_read(8'h32, b, f);
    check(b == 8'hFF && f, "R4 check bit p32", {f, b}, 9'h1FF);
    do_read(8'h24, b, f);
    check(b == 8'hFF && !f, "R5 clean unit flag low", {f, b}, 8'hFF);

    // R8: write into unit 0x10 that still holds a data error
    do_write(8'h12, 8'h77);
    check(arr[4] == tb_syn(arr[4]) * 0 + arr[4] && tb_syn(arr[4]) == 0, "R8 stored clean", tb_syn(arr[4]), 0);
    do_read(8'h10, b, f);
    check(b == 8'h11 && !f, "R8 lane0 after rmw", {f, b}, 8'h11);
    do_read(8'h12, b, f);
    check(b == 8'h77 && !f, "R6 merged lane", {f, b}, 8'h77);
    do_read(8'h11, b, f);
    check(b == 8'hBB && !f, "R6 lane kept", {f, b}, 8'hBB);

    // R7: busy timing and request ignored while busy
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 8'h40; req_wbyte = 8'h99;
    @(negedge clk);
    check(busy, "R7 busy cycle 1", busy, 1);
    req_addr = 8'h44; req_wbyte = 8'h55;
    @(negedge clk);
    check(busy, "R7 busy cycle 2", busy, 1);
    @(negedge clk);
    req_valid = 0;
    check(!busy, "R7 busy released", busy, 0);
    do_read(8'h44, b, f);
    check(b == 8'hFF, "R7 busy request ignored", b, 8'hFF);
    do_read(8'h40, b, f);
    check(b == 8'h99 && !f, "R7 accepted write", {f, b}, 8'h99);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule